// File: doc/BRIEF.md
# SIMD Widening Lane Multiplier

This unit is a 128-bit vector execution stage for widening integer multiplies. Each operation takes two 128-bit operand vectors and an opcode. The opcode picks one of three lane shapes: 8-bit, 16-bit or 32-bit source lanes. It also picks the lower or upper half of the source lanes, and signed or unsigned extension. The unit widens every selected lane to twice its width and multiplies the operands lane by lane. The result vector holds the full, unwrapped products.

Operations enter through a valid/opcode/operand port and leave through a valid/result port two cycles later. The unit takes a new operation on every cycle and never stalls. An opcode outside the supported range gives a zero result, and an illegal flag is raised together with the output valid.

Top module: `simd_extmul_unit`

## Requirements
- R1: The 12-bit opcode is fully decoded over 0x110..0x11B. Bits [3:2] of (opcode − 0x110) pick the shape: 0 means 8-bit lanes giving eight 16-bit products, 1 means 16-bit lanes giving four 32-bit products, and 2 means 32-bit lanes giving two 64-bit products. Bit 0 selects the upper half of the lanes. Bit 1 selects unsigned extension.
- R2: Source lane i of lane width w occupies bits [i*w +: w]. A low-half operation uses lanes 0..N/2−1 and a high-half operation uses lanes N/2..N−1, where N is the number of source lanes. Output lane j (width 2w, at bits [j*2w +: 2w]) is the product of selected lane j of each operand.
- R3: A signed operation sign-extends both selected lanes and gives the exact two's-complement product. For example, the most negative value times itself gives 0x4000, 0x4000_0000 or 0x4000_0000_0000_0000.
- R4: An unsigned operation zero-extends both selected lanes and gives the exact product. For example, all-ones times all-ones gives 0xFE01 per 16-bit lane.
- R5: An opcode outside 0x110..0x11B gives result_o = 0 with illegal_o = 1 in the same cycle as valid_o. This includes opcodes that differ from a legal one only in bits above bit 8.
- R6: valid_o follows valid_i exactly two clock cycles later. A new operation is accepted on every cycle with no bubbles.
- R7: While rst_ni is low, valid_o and illegal_o are 0 and result_o is 0.
- R8: When valid_o is 0, result_o is 0 and illegal_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present |
| opcode_i | input | 12 | Operation code |
| a_i | input | 128 | First operand vector |
| b_i | input | 128 | Second operand vector |
| valid_o | output | 1 | Result present |
| illegal_o | output | 1 | Opcode was not a widening multiply |
| result_o | output | 128 | Vector of double-width products |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector, 8-bit narrowest lanes and a 12-bit opcode. With these values all three shapes and all twelve opcodes are reachable, along with the 64-bit product lanes, where a wrapped result would show up first. The 12-bit opcode also lets the bench set bits above bit 8, so it can confirm that decode looks at the whole field and not only the low byte.

// File: rtl/extmul_pkg.sv
package extmul_pkg;
  localparam int unsigned NUM_SHAPES = 3;
  localparam int unsigned NUM_OPS    = 4 * NUM_SHAPES;

  typedef struct packed {
    logic       legal;
    logic [1:0] shape;
    logic       hi;
    logic       sgn;
  } extmul_op_t;
endpackage

// File: rtl/extmul_decode.sv
module extmul_decode
  import extmul_pkg::*;
#(
  parameter int unsigned OPC_W    = 12,
  parameter int unsigned OPC_BASE = 'h110
) (
  input  logic [OPC_W-1:0] opcode_i,
  output extmul_op_t       op_o
);
  logic [OPC_W-1:0] off;

  always_comb begin
    off         = opcode_i - OPC_W'(OPC_BASE);
    op_o.legal  = (opcode_i >= OPC_W'(OPC_BASE)) && (off < OPC_W'(NUM_OPS));
    op_o.shape  = off[3:2];
    op_o.hi     = off[0];
    op_o.sgn    = ~off[1];
  end
endmodule

// File: rtl/extmul_half_select.sv
module extmul_half_select #(
  parameter int unsigned VEC_W = 128
) (
  input  logic               hi_i,
  input  logic [VEC_W-1:0]   a_i,
  input  logic [VEC_W-1:0]   b_i,
  output logic [VEC_W/2-1:0] a_o,
  output logic [VEC_W/2-1:0] b_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  always_comb begin
    a_o = hi_i ? a_i[VEC_W-1:HALF_W] : a_i[HALF_W-1:0];
    b_o = hi_i ? b_i[VEC_W-1:HALF_W] : b_i[HALF_W-1:0];
  end
endmodule

// File: rtl/extmul_lane_array.sv
module extmul_lane_array
  import extmul_pkg::*;
#(
  parameter int unsigned HALF_W = 64,
  parameter int unsigned BASE_W = 8
) (
  input  logic [HALF_W-1:0]   a_i,
  input  logic [HALF_W-1:0]   b_i,
  input  logic [1:0]          shape_i,
  input  logic                sgn_i,
  output logic [2*HALF_W-1:0] prod_o
);
  logic [2*HALF_W-1:0] shape_res [NUM_SHAPES];

  for (genvar s = 0; s < NUM_SHAPES; s++) begin : g_shape
    localparam int unsigned W  = BASE_W << s;
    localparam int unsigned NL = HALF_W / W;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [W-1:0]   la, lb;
      logic [2*W-1:0] ea, eb, p;
      always_comb begin
        la = a_i[l*W +: W];
        lb = b_i[l*W +: W];
        ea = {{W{sgn_i & la[W-1]}}, la};
        eb = {{W{sgn_i & lb[W-1]}}, lb};
        // low 2W bits of the extended product are the exact result
        p  = ea * eb;
      end
      assign shape_res[s][l*2*W +: 2*W] = p;
    end
  end

  always_comb begin
    prod_o = '0;
    for (int s = 0; s < NUM_SHAPES; s++)
      if (shape_i == 2'(s)) prod_o = shape_res[s];
  end
endmodule

// File: rtl/simd_extmul_unit.sv
module simd_extmul_unit
  import extmul_pkg::*;
#(
  parameter int unsigned VEC_W    = 128,
  parameter int unsigned BASE_W   = 8,
  parameter int unsigned OPC_W    = 12,
  parameter int unsigned OPC_BASE = 'h110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             valid_o,
  output logic             illegal_o,
  output logic [VEC_W-1:0] result_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  extmul_op_t        dec_op, s1_op;
  logic [HALF_W-1:0] sel_a, sel_b, s1_a, s1_b;
  logic              s1_v;
  logic [VEC_W-1:0]  prod;

  extmul_decode #(.OPC_W(OPC_W), .OPC_BASE(OPC_BASE)) u_dec (
    .opcode_i (opcode_i),
    .op_o     (dec_op)
  );

  extmul_half_select #(.VEC_W(VEC_W)) u_sel (
    .hi_i (dec_op.hi),
    .a_i  (a_i),
    .b_i  (b_i),
    .a_o  (sel_a),
    .b_o  (sel_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v  <= 1'b0;
      s1_op <= '0;
      s1_a  <= '0;
      s1_b  <= '0;
    end else begin
      s1_v  <= valid_i;
      s1_op <= valid_i ? dec_op : '0;
      s1_a  <= valid_i ? sel_a : '0;
      s1_b  <= valid_i ? sel_b : '0;
    end
  end

  extmul_lane_array #(.HALF_W(HALF_W), .BASE_W(BASE_W)) u_mul (
    .a_i     (s1_a),
    .b_i     (s1_b),
    .shape_i (s1_op.shape),
    .sgn_i   (s1_op.sgn),
    .prod_o  (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= s1_v;
      illegal_o <= s1_v & ~s1_op.legal;
      result_o  <= (s1_v && s1_op.legal) ? prod : '0;
    end
  end
endmodule

// File: rtl/simd_extmul_unit_checker.sv
module simd_extmul_unit_checker #(
  parameter int unsigned VEC_W    = 128,
  parameter int unsigned OPC_W    = 12,
  parameter int unsigned OPC_BASE = 'h110
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic [VEC_W-1:0] a_i,
  input logic             valid_o,
  input logic             illegal_o,
  input logic [VEC_W-1:0] result_o
);
  logic [1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> (valid_o == $past(valid_i, 2))); // R6

  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_o && result_o == '0)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0 && !illegal_o)); // R8

  AST_FULL_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && valid_o) |->
      (illegal_o == ($past(opcode_i, 2) < OPC_W'(OPC_BASE) ||
                     $past(opcode_i, 2) > OPC_W'(OPC_BASE + 11)))); // R1

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && valid_o && $past(a_i, 2) == '0) |-> (result_o == '0)); // R3

  always_comb begin
    if (!rst_ni) AST_RESET_IDLE: assert (!valid_o && !illegal_o && result_o == '0); // R7
  end
endmodule

bind simd_extmul_unit simd_extmul_unit_checker #(
  .VEC_W(VEC_W), .OPC_W(OPC_W), .OPC_BASE(OPC_BASE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .opcode_i  (opcode_i),
  .a_i       (a_i),
  .valid_o   (valid_o),
  .illegal_o (illegal_o),
  .result_o  (result_o)
);

// File: tb/simd_extmul_unit_bench.sv
module simd_extmul_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [11:0]  opcode_i = '0;
  logic [127:0] a_i = '0, b_i = '0;
  logic         valid_o, illegal_o;
  logic [127:0] result_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic         q_v[$];
  logic         q_ill[$];
  logic [127:0] q_res[$];
  string        q_tag[$];

  always #5 clk = ~clk;

  simd_extmul_unit u_simd_extmul_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  function automatic logic [128:0] ref_model(logic [11:0] opc, logic [127:0] a, logic [127:0] b);
    logic [127:0] res = '0;
    int off, shape, w, nl, base;
    bit sgn, hi;
    if (opc < 12'h110 || opc > 12'h11B) return {1'b1, 128'd0};
    off = int'(opc) - 'h110;
    shape = off / 4; hi = (off % 2) == 1; sgn = ((off / 2) % 2) == 0;
    w = 8 << shape; nl = 64 / w; base = hi ? nl : 0;
    for (int j = 0; j < nl; j++) begin
      logic [127:0] m1  = (128'd1 << w) - 1;
      logic [127:0] m2  = (w == 64) ? '1 : ((128'd1 << (2 * w)) - 1);
      logic [127:0] ra  = (a >> ((base + j) * w)) & m1;
      logic [127:0] rb  = (b >> ((base + j) * w)) & m1;
      longint xa = longint'(ra[63:0]);
      longint xb = longint'(rb[63:0]);
      longint p;
      logic [127:0] pp;
      if (sgn && ra[w-1]) xa = xa - (longint'(1) << w);
      if (sgn && rb[w-1]) xb = xb - (longint'(1) << w);
      p  = xa * xb;
      pp = 128'(p) & m2;
      res = res | (pp << (j * 2 * w));
    end
    return {1'b0, res};
  endfunction

  task automatic push_exp(logic v, logic [11:0] opc, logic [127:0] a, logic [127:0] b, string tag);
    logic [128:0] r = ref_model(opc, a, b);
    q_v.push_back(v);
    q_ill.push_back(v & r[128]);
    q_res.push_back(v ? r[127:0] : '0);
    q_tag.push_back(v ? tag : "R8");
  endtask

  task automatic step(logic v, logic [11:0] opc, logic [127:0] a, logic [127:0] b, string tag);
    @(negedge clk);
    if (q_v.size() >= 2) begin
      logic ev = q_v.pop_front();
      logic ei = q_ill.pop_front();
      logic [127:0] er = q_res.pop_front();
      string et = q_tag.pop_front();
      checks++;
      if (valid_o !== ev || illegal_o !== ei || result_o !== er) begin
        errors++;
        $display("FAIL %s: got v=%b ill=%b res=%h, expected v=%b ill=%b res=%h",
                 et, valid_o, illegal_o, result_o, ev, ei, er);
      end
    end
    valid_i = v; opcode_i = opc; a_i = a; b_i = b;
    push_exp(v, opc, a, b, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: got cycles=%0d, expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [127:0] lanes_a = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  logic [127:0] lanes_b = 128'h7F017E028003FF04FE05A5065A07C308;

  initial begin
    repeat (2) @(negedge clk);
    // R7: reset state
    checks++;
    if (valid_o !== 1'b0 || illegal_o !== 1'b0 || result_o !== '0) begin
      errors++;
      $display("FAIL R7: got v=%b ill=%b res=%h, expected 0 0 0", valid_o, illegal_o, result_o);
    end
    push_exp(0, '0, '0, '0, "R8");
    push_exp(0, '0, '0, '0, "R8");
    rst_n = 1'b1;

    // R1: every legal opcode on mixed lanes
    for (int k = 0; k < 12; k++) step(1, 12'h110 + 12'(k), lanes_a, lanes_b, "R1");
    // R2: only upper half populated, then only lower half
    for (int k = 0; k < 12; k++) step(1, 12'h110 + 12'(k), {lanes_a[127:64], 64'd0}, lanes_b, "R2");
    for (int k = 0; k < 12; k++) step(1, 12'h110 + 12'(k), {64'd0, lanes_a[63:0]}, lanes_b, "R2");
    step(0, '0, '0, '0, "R8");
    step(0, 12'h110, '1, '1, "R8");
    // R3: most negative squared, -1 times max positive
    step(1, 12'h110, {16{8'h80}}, {16{8'h80}}, "R3");
    step(1, 12'h115, {8{16'h8000}}, {8{16'h8000}}, "R3");
    step(1, 12'h118, {4{32'h80000000}}, {4{32'h80000000}}, "R3");
    step(1, 12'h119, {4{32'hFFFFFFFF}}, {4{32'h7FFFFFFF}}, "R3");
    step(1, 12'h114, {8{16'h8000}}, {8{16'h7FFF}}, "R3");
    // R4: all ones unsigned in each shape
    step(1, 12'h112, '1, '1, "R4");
    step(1, 12'h117, '1, '1, "R4");
    step(1, 12'h11A, '1, '1, "R4");
    step(1, 12'h11B, {4{32'h80000000}}, '1, "R4");
    // R5: illegal opcodes including high-bit aliases
    step(1, 12'h10F, '1, '1, "R5");
    step(1, 12'h11C, '1, '1, "R5");
    step(1, 12'h010, '1, '1, "R5");
    step(1, 12'h910, '1, '1, "R5");
    step(1, 12'h000, '1, '1, "R5");
    step(0, '0, '0, '0, "R8");
    // R6: back-to-back random stream with occasional idles
    for (int k = 0; k < 300; k++) begin
      logic [11:0] opc = (k % 17 == 0) ? 12'($urandom) : 12'h110 + 12'($urandom_range(0, 11));
      step((k % 11) != 5, opc,
           {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, "R6");
    end
    step(0, '0, '0, '0, "R8");
    step(0, '0, '0, '0, "R8");
    step(0, '0, '0, '0, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule